// File: doc/BRIEF.md
# Serial byte memory slave with hold and status protection

This block is the serial front end of a byte-wide memory. It works as an SPI mode-0 slave. A host lowers chip select and shifts in an 8-bit command, most significant bit first. The command may be followed by a two-byte address and then by data bytes. Reads and writes run as bursts: an address counter steps after every byte and rolls over from 0xFFFF to 0x0000. The storage is a small register array behind one synchronous port, so that block RAM can be inferred. It is indexed by the low `MEM_AW` bits of the address counter.

The slave also holds a status byte. Bit 1 of that byte mirrors a write-enable latch. Any array write or status write needs that latch. A write-protect input blocks status writes only. An active-low hold input freezes a transfer at any bit: clock and select activity is ignored and the output is released until hold returns high. The serial output is brought out as a data bit plus an enable, so the pad's tri-state buffer sits outside the block. All serial pins are synchronised into the system clock and then edge-detected there.

Commands: 0x06 sets the latch, 0x04 clears it, 0x05 reads status, 0x01 writes status, 0x03 reads the array and 0x02 writes the array.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset, `miso_oe` is 0 and a status read (command 0x05) returns 0x00.
- R2: While `cs_n` is high, clock edges and data on `mosi` have no effect and `miso_oe` stays 0.
- R3: A command is taken only from the first byte after a falling edge of `cs_n`. A byte that is not one of the six codes causes every later byte of that select to be ignored.
- R4: Command 0x06 sets the write-enable latch and command 0x04 clears it. The latch reads back as bit 1 of the status byte.
- R5: Command 0x02, sent with the latch set, stores the data bytes that follow the two address bytes (high byte first) at consecutive addresses, starting at the given address. Bytes are shifted most significant bit first.
- R6: An array write or a status write issued while the latch is clear changes nothing.
- R7: Command 0x03 returns the bytes stored at consecutive addresses from the given address, most significant bit first. Each output bit changes on a falling edge of `sclk`, so it is valid before the next rising edge.
- R8: The address counter wraps from 0xFFFF to 0x0000 within a burst.
- R9: The latch clears when `cs_n` rises at the end of any array write or status write, whether or not the write took effect.
- R10: Command 0x01, sent with the latch set, writes status bits 7..2 and 0 from its data byte. Bit 1 is read-only.
- R11: With `wp_n` low, status writes are refused, but array writes still take effect.
- R12: While hold is low, `miso_oe` is 0, `sclk` edges are ignored, and no array write happens. When hold returns high the transfer resumes at the bit where it stopped.
- R13: `miso_oe` is 1 only during the data phase of a read (0x03 or 0x05). It is 0 during the command, address and write-data phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every serial pin is sampled with it |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, mode 0 (idles low) |
| mosi | input | 1 | Serial data in, sampled on the rising `sclk` edge |
| hold_n | input | 1 | Active-low hold; change it only while `sclk` is low |
| wp_n | input | 1 | Active-low write protect for the status byte |
| miso | output | 1 | Serial data out, updated on the falling `sclk` edge |
| miso_oe | output | 1 | Output enable for the external tri-state buffer on `miso` |

## Verification
Every pin passes two synchroniser stages and an edge-detect register, so a pin change reaches the control logic 3 to 4 clocks later. A registered output moves about one clock after that. The bench holds each half of `sclk` for ten system clocks. It samples `miso` and `miso_oe` at the end of the low half, about six clocks after the falling edge's effect has landed. This also leaves a data fetch (two RAM cycles after a byte completes) time to finish before the next falling edge. Hold is changed and released only while `sclk` is low. The bench then waits a full half period before it resumes clocking, so the hold register has settled before any edge it must gate.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_SET_WEL  = 8'h06;
  localparam logic [BYTE_W-1:0] CMD_CLR_WEL  = 8'h04;
  localparam logic [BYTE_W-1:0] CMD_GET_STAT = 8'h05;
  localparam logic [BYTE_W-1:0] CMD_PUT_STAT = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_READ     = 8'h03;
  localparam logic [BYTE_W-1:0] CMD_WRITE    = 8'h02;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_RD_DATA,
    PH_WR_DATA,
    PH_RD_STAT,
    PH_WR_STAT,
    PH_SKIP
  } phase_t;

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int          N          = 5,
  parameter int          STAGES     = 2,
  parameter logic [N-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL[g]}};
        else     chain <= {chain[STAGES-2:0], din[g]};
      end
      assign dout[g] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/spi_mem_edge.sv
module spi_mem_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk_s,
  input  logic hold_s,
  output logic hold_ok,
  output logic sclk_rise,
  output logic sclk_fall
);

  logic sclk_d;

  // hold is taken only while the serial clock is low
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_ok <= 1'b1;
      sclk_d  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      if (!sclk_s) hold_ok <= hold_s;
    end
  end

  assign sclk_rise = hold_ok &&  sclk_s && !sclk_d;
  assign sclk_fall = hold_ok && !sclk_s &&  sclk_d;

endmodule

// File: rtl/spi_mem_ram.sv
module spi_mem_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              mosi_s,
  input  logic              wp_s,
  input  logic              hold_ok,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              miso,
  output logic              miso_oe
);

  localparam int BIT_W          = $clog2(BYTE_W);
  localparam int ADDR_BYTES     = ADDR_W / BYTE_W;
  localparam logic [3:0] LAST_AB = 4'(ADDR_BYTES - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  phase_t            phase;
  logic              cs_d;
  logic [BYTE_W-2:0] shreg;
  logic [BIT_W-1:0]  bitcnt;
  logic [3:0]        abytes;
  logic [ADDR_W-1:0] addr_q;
  logic              wel;
  logic [5:0]        stat_hi;
  logic              stat_lo;
  logic              is_read;
  logic              wr_op;
  logic [BYTE_W-1:0] tx;
  logic [1:0]        fetch;

  logic              cs_fall, cs_rise, byte_done, rd_phase;
  logic [BYTE_W-1:0] byte_in;
  logic [BYTE_W-1:0] status;
  logic [ADDR_W-1:0] addr_next;
  logic [ADDR_W-1:0] addr_inc;

  assign cs_fall   = hold_ok && !cs_s &&  cs_d;
  assign cs_rise   = hold_ok &&  cs_s && !cs_d;
  assign byte_in   = {shreg, mosi_s};
  assign byte_done = (bitcnt == LAST_BIT);
  assign status    = {stat_hi, wel, stat_lo};
  assign addr_next = {addr_q[ADDR_W-BYTE_W-1:0], byte_in};
  assign addr_inc  = addr_q + ADDR_W'(1);
  assign rd_phase  = (phase == PH_RD_DATA) || (phase == PH_RD_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cs_d      <= 1'b1;
      shreg     <= '0;
      bitcnt    <= '0;
      abytes    <= '0;
      addr_q    <= '0;
      wel       <= 1'b0;
      stat_hi   <= '0;
      stat_lo   <= 1'b0;
      is_read   <= 1'b0;
      wr_op     <= 1'b0;
      tx        <= '0;
      fetch     <= '0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      miso      <= 1'b0;
      miso_oe   <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      fetch   <= {fetch[0], 1'b0};
      miso_oe <= hold_ok && !cs_s && rd_phase;
      if (hold_ok) cs_d <= cs_s;
      if (fetch[1]) tx <= mem_rdata;

      if (cs_rise) begin
        phase <= PH_IDLE;
        if (wr_op) wel <= 1'b0;
        wr_op <= 1'b0;
      end else if (cs_fall) begin
        phase  <= PH_CMD;
        bitcnt <= '0;
        abytes <= '0;
      end else if (sclk_rise && !cs_s && phase != PH_IDLE) begin
        shreg  <= byte_in[BYTE_W-2:0];
        bitcnt <= bitcnt + BIT_W'(1);
        if (byte_done) begin
          unique case (phase)
            PH_CMD: begin
              unique case (byte_in)
                CMD_SET_WEL: begin wel <= 1'b1; phase <= PH_SKIP; end
                CMD_CLR_WEL: begin wel <= 1'b0; phase <= PH_SKIP; end
                CMD_GET_STAT: begin tx <= status; phase <= PH_RD_STAT; end
                CMD_PUT_STAT: begin wr_op <= 1'b1; phase <= PH_WR_STAT; end
                CMD_READ: begin is_read <= 1'b1; phase <= PH_ADDR; end
                CMD_WRITE: begin
                  is_read <= 1'b0;
                  wr_op   <= 1'b1;
                  phase   <= PH_ADDR;
                end
                default: phase <= PH_SKIP;
              endcase
            end
            PH_ADDR: begin
              addr_q <= addr_next;
              abytes <= abytes + 4'd1;
              if (abytes == LAST_AB) begin
                if (is_read) begin
                  mem_addr <= addr_next[MEM_AW-1:0];
                  fetch[0] <= 1'b1;
                  phase    <= PH_RD_DATA;
                end else begin
                  phase <= PH_WR_DATA;
                end
              end
            end
            PH_RD_DATA: begin
              addr_q   <= addr_inc;
              mem_addr <= addr_inc[MEM_AW-1:0];
              fetch[0] <= 1'b1;
            end
            PH_WR_DATA: begin
              mem_addr  <= addr_q[MEM_AW-1:0];
              mem_wdata <= byte_in;
              mem_we    <= wel;
              addr_q    <= addr_inc;
            end
            PH_RD_STAT: tx <= status;
            PH_WR_STAT: begin
              if (wel && wp_s) begin
                stat_hi <= byte_in[BYTE_W-1:2];
                stat_lo <= byte_in[0];
              end
              phase <= PH_SKIP;
            end
            default: ;
          endcase
        end
      end else if (sclk_fall && !cs_s && rd_phase) begin
        miso <= tx[~bitcnt];
      end
    end
  end

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int MEM_AW      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  input  logic hold_n,
  input  logic wp_n,
  output logic miso,
  output logic miso_oe
);

  localparam int NPIN = 5;

  logic [NPIN-1:0]   pins_s;
  logic              cs_s, sclk_s, mosi_s, hold_s, wp_s;
  logic              hold_ok, sclk_rise, sclk_fall;
  logic [MEM_AW-1:0] mem_addr;
  logic              mem_we;
  logic [BYTE_W-1:0] mem_wdata, mem_rdata;

  spi_mem_sync #(
    .N(NPIN), .STAGES(SYNC_STAGES), .RESET_VAL(5'b11001)
  ) u_sync (
    .clk(clk), .rst(rst),
    .din({wp_n, hold_n, mosi, sclk, cs_n}),
    .dout(pins_s)
  );

  assign cs_s   = pins_s[0];
  assign sclk_s = pins_s[1];
  assign mosi_s = pins_s[2];
  assign hold_s = pins_s[3];
  assign wp_s   = pins_s[4];

  spi_mem_edge u_edge (
    .clk(clk), .rst(rst),
    .sclk_s(sclk_s), .hold_s(hold_s),
    .hold_ok(hold_ok), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
  );

  spi_mem_ctrl #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_ctrl (
    .clk(clk), .rst(rst),
    .cs_s(cs_s), .mosi_s(mosi_s), .wp_s(wp_s), .hold_ok(hold_ok),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .miso(miso), .miso_oe(miso_oe)
  );

  spi_mem_ram #(.AW(MEM_AW), .DW(BYTE_W)) u_ram (
    .clk(clk), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );

endmodule

// File: rtl/spi_mem_chk.sv
module spi_mem_chk #(
  parameter int MEM_AW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_s,
  input logic              hold_ok,
  input logic              miso_oe,
  input logic              mem_we,
  input logic [MEM_AW-1:0] mem_addr
);

  logic              seen;
  logic [MEM_AW-1:0] last_addr;

  always_ff @(posedge clk) begin
    if (rst || cs_s) begin
      seen      <= 1'b0;
      last_addr <= '0;
    end else if (mem_we) begin
      seen      <= 1'b1;
      last_addr <= mem_addr;
    end
  end

  a_r1_oe_low_after_reset: assert property (@(posedge clk) rst |=> !miso_oe);

  a_r2_deselect_releases_out: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !miso_oe);

  a_r12_hold_releases_out: assert property (@(posedge clk) disable iff (rst)
    !hold_ok |=> !miso_oe);

  a_r12_hold_blocks_write: assert property (@(posedge clk) disable iff (rst)
    !hold_ok |=> !mem_we);

  a_r5_single_cycle_write: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R8: successive writes of one burst step by one, wrapping at the top
  a_r8_write_addr_step: assert property (@(posedge clk) disable iff (rst)
    (mem_we && seen) |-> (mem_addr == MEM_AW'(last_addr + 1'b1)));

endmodule

bind spi_mem_slave spi_mem_chk #(.MEM_AW(MEM_AW)) u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .hold_ok(hold_ok),
  .miso_oe(miso_oe), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/spi_mem_slave_tb.sv
`timescale 1ns/1ps
module spi_mem_slave_tb;

  localparam int HALF   = 80;     // ten 8 ns system clocks
  localparam int NOHOLD = 99;

  logic clk = 1'b0;
  logic rst, cs_n, sclk, mosi, hold_n, wp_n;
  logic miso, miso_oe;

  int errors = 0;
  int checks = 0;

  logic [7:0] wbuf [256];

  always #4 clk = ~clk;

  spi_mem_slave u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .hold_n(hold_n), .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) ^ 8'h5A);
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // one byte; oe_exp 0/1 checks miso_oe at each sample, 2 skips
  task automatic xfer(input logic [7:0] b, input int hold_at, input int oe_exp,
                      input string tag, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      #HALF;
      if (7 - i == hold_at) begin
        hold_n = 1'b0;
        #HALF;
        chk({tag, " R12 oe in hold"}, {7'd0, miso_oe}, 8'd0);
        repeat (3) begin
          sclk = 1'b1; mosi = ~mosi; #HALF;
          sclk = 1'b0; #HALF;
        end
        chk({tag, " R12 oe in hold late"}, {7'd0, miso_oe}, 8'd0);
        mosi = b[i];
        hold_n = 1'b1;
        #HALF;
      end
      rx[i] = miso;
      if (oe_exp != 2) chk({tag, " R13 oe"}, {7'd0, miso_oe}, 8'(oe_exp));
      sclk = 1'b1;
      #HALF;
      sclk = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0; #HALF;
  endtask

  task automatic desel();
    #HALF; cs_n = 1'b1; #(4 * HALF);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] rx;
    sel(); xfer(op, NOHOLD, 0, "cmd", rx); desel();
  endtask

  task automatic stat_check(input string tag, input logic [7:0] exp);
    logic [7:0] rx;
    sel();
    xfer(8'h05, NOHOLD, 0, tag, rx);
    xfer(8'h00, NOHOLD, 1, tag, rx);
    desel();
    chk(tag, rx, exp);
  endtask

  task automatic stat_write(input logic [7:0] v);
    logic [7:0] rx;
    sel();
    xfer(8'h01, NOHOLD, 0, "wrsr", rx);
    xfer(v, NOHOLD, 0, "wrsr", rx);
    desel();
  endtask

  task automatic mem_write(input logic [15:0] a, input int n);
    logic [7:0] rx;
    sel();
    xfer(8'h02, NOHOLD, 0, "R5 wr", rx);
    xfer(a[15:8], NOHOLD, 0, "R5 wr", rx);
    xfer(a[7:0], NOHOLD, 0, "R5 wr", rx);
    for (int k = 0; k < n; k++) xfer(wbuf[k], NOHOLD, 0, "R5 wr", rx);
    desel();
  endtask

  // checks n bytes read from a against wbuf; hold inserted in byte hb at bit hbit
  task automatic mem_read(input logic [15:0] a, input int n, input string tag,
                          input int hb, input int hbit);
    logic [7:0] rx;
    sel();
    xfer(8'h03, NOHOLD, 0, tag, rx);
    xfer(a[15:8], NOHOLD, 0, tag, rx);
    xfer(a[7:0], NOHOLD, 0, tag, rx);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, (k == hb) ? hbit : NOHOLD, 1, tag, rx);
      chk(tag, rx, wbuf[k]);
    end
    desel();
  endtask

  initial begin
    #(190000 * 8);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0; hold_n = 1'b1; wp_n = 1'b1;
    repeat (6) @(posedge clk);
    #2 rst = 1'b0;
    #(2 * HALF);

    // R1 reset state
    chk("R1 oe after reset", {7'd0, miso_oe}, 8'd0);
    stat_check("R1 status after reset", 8'h00);

    // R2 traffic with select high is ignored
    xfer(8'h06, NOHOLD, 0, "R2 deselected", rx);
    #(4 * HALF);
    stat_check("R2 latch untouched", 8'h00);

    // R4 latch set / clear
    cmd(8'h06);
    stat_check("R4 latch set", 8'h02);
    cmd(8'h04);
    stat_check("R4 latch cleared", 8'h00);

    // R3 unknown command swallows the rest of the select
    sel();
    xfer(8'hFF, NOHOLD, 0, "R3", rx);
    xfer(8'h06, NOHOLD, 0, "R3", rx);
    desel();
    stat_check("R3 late command ignored", 8'h00);

    // R10 / R9 / R6 status writes
    cmd(8'h06);
    stat_write(8'hFF);
    stat_check("R10 status write, R9 latch cleared", 8'hFD);
    stat_write(8'h00);
    stat_check("R6 status write without latch", 8'hFD);
    cmd(8'h06);
    stat_write(8'h02);
    stat_check("R10 bit1 read-only", 8'h00);

    // R11 protect pin blocks status only
    wp_n = 1'b0;
    cmd(8'h06);
    stat_write(8'hAA);
    stat_check("R11 protected status", 8'h00);
    cmd(8'h06);
    wbuf[0] = 8'h3C;
    mem_write(16'h0010, 1);
    stat_check("R9 latch cleared after write", 8'h00);
    mem_read(16'h0010, 1, "R11 array writable", NOHOLD, 0);
    wp_n = 1'b1;

    // R6 array write without latch
    wbuf[0] = 8'h99;
    mem_write(16'h0010, 1);
    wbuf[0] = 8'h3C;
    mem_read(16'h0010, 1, "R6 array write refused", NOHOLD, 0);

    // R5 / R7 / R13 full-array burst
    for (int k = 0; k < 256; k++) wbuf[k] = pat(k);
    cmd(8'h06);
    mem_write(16'h0000, 256);
    mem_read(16'h0000, 256, "R7 burst read", NOHOLD, 0);

    // R8 wrap from 0xFFFF
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    cmd(8'h06);
    mem_write(16'hFFFF, 2);
    mem_read(16'hFFFF, 2, "R8 wrap read", NOHOLD, 0);
    wbuf[0] = 8'h22;
    mem_read(16'h0000, 1, "R8 wrapped byte", NOHOLD, 0);

    // R12 hold in the middle of a read byte
    for (int k = 0; k < 3; k++) wbuf[k] = pat(16'h40 + k);
    mem_read(16'h0040, 3, "R12 read across hold", 1, 3);
    chk("R12 oe after select end", {7'd0, miso_oe}, 8'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule